// File: doc/BRIEF.md
# Interrupt Arbiter and Low-Power Wake Controller

This block sits beside a small 8-bit processor core. It collects every reason the core may have to leave its current instruction stream: the reset pin, a software-interrupt instruction, three active-low external request pins and three peripheral request lines. The peripherals are the real-time clock, the timer and the serial interface. The block picks one request by fixed priority and hands the core the address of the two-byte service vector. It also tells the core whether to save its state on the stack, and it always tells the core to set its interrupt mask. The hardware sources are honoured only while the core's mask input is clear. The software interrupt and reset ignore the mask.

The block also owns the clock gating for the two sleep states. A stop strobe gates the processor clock. If the real-time clock is configured as interrupt-driven, the stop strobe also shuts the oscillator and, with it, every other clock, and only an external pin can then resume execution. A wait strobe halts only the processor clock and keeps the peripheral clocks running. Either an external pin or a peripheral request can end a wait. On wake the clocks return one cycle before any vector is issued. Each external pin can be set to latch falling edges or to follow its low level. The pins pass through a synchronizer before detection. The controller itself is assumed to run on an always-on clock.

Top module: `intWakeCtrl`

## Requirements
- R1: While `rstN` is low, `oscEn`, `cpuClkEn` and `perClkEn` are all 1 and `vecValid` is 0. This also holds when reset arrives during a deep stop. In the cycle after the first clock edge following release, `vecValid` is 1, `vecAddr` is 16'h3FFE, `setMask` is 1 and `pushReq` is 0.
- R2: A `swiStb` pulse yields a vector at 16'h3FFC with `pushReq` and `setMask` at 1, even while `iMask` is 1. The vector is visible two cycles after the strobe.
- R3: No external or peripheral source produces a vector while `iMask` is 1. Pending sources are served once `iMask` clears.
- R4: Source indices run as follows: reset 0, software 1, external pins 2 to 4 (`extPinN[0..2]`), peripherals 5 to 7 (`perReq[0..2]`: clock, timer, serial). A lower index wins. Source k uses vector address 16'h3FFE − 2k. `vecValid` lasts one cycle, and successive vectors are at least two cycles apart.
- R5: With `edgeSel[i]`=1, a falling edge on `extPinN[i]` is remembered after the pin returns high, and the vector appears 4 cycles after the edge. Serving the request clears the latch, so no second vector follows.
- R6: With `edgeSel[i]`=0, the request exists only while the synchronized pin is low. A low pulse that ends while masked leaves nothing behind. With the mask clear, the vector appears 3 cycles after the pin falls.
- R7: When `stopStb` arrives with `rtcIntMode`=1, all three clock enables drop to 0 in the next cycle. A peripheral request does not wake the block from this state.
- R8: When `stopStb` arrives with `rtcIntMode`=0, only `cpuClkEn` drops to 0, and `oscEn` and `perClkEn` stay at 1.
- R9: `waitStb` drops only `cpuClkEn`. A peripheral or external request ends the wait.
- R10: A wake source sets `cpuClkEn` to 1 one cycle before any vector. If `iMask` is 1, the clocks return but no vector is issued, and the request stays pending.
- R11: A peripheral vector comes with a one-hot `perAck` pulse for that peripheral in the same cycle.
- R12: If a sleep strobe and a request arrive in the same cycle, the sleep state is entered first. The block wakes at the next edge and issues the vector one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Active-low reset pin, asynchronous |
| extPinN | input | 3 | Active-low external request pins |
| edgeSel | input | 3 | Per pin: 1 falling-edge latched, 0 level |
| perReq | input | 3 | Peripheral requests: clock, timer, serial |
| iMask | input | 1 | Core interrupt mask bit |
| swiStb | input | 1 | Software interrupt executed |
| stopStb | input | 1 | Stop instruction executed |
| waitStb | input | 1 | Wait instruction executed |
| rtcIntMode | input | 1 | Real-time clock runs interrupt-driven |
| vecValid | output | 1 | Vector fetch starts this cycle |
| vecAddr | output | 16 | Address of vector high byte |
| pushReq | output | 1 | Core must stack its state |
| setMask | output | 1 | Core must set its mask |
| perAck | output | 3 | Peripheral request accepted |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | Processor clock enable |
| perClkEn | output | 1 | Peripheral clock enable |

## Verification
Two functions can meet in one clock edge: entry into a sleep state and the selection of a vector. The bench provokes this by raising a wait strobe in the same cycle as a serial-interface request. It then checks cycle by cycle that the processor clock drops, returns one edge later, and that the serial vector follows one edge after that. A second overlap occurs when a wake source arrives while the mask is set. There the bench requires the clocks back with no vector, and it requires the vector exactly one cycle after the mask is cleared.

// File: rtl/iwcPkg.sv
package iwcPkg;
  localparam int N_EXT    = 3;
  localparam int N_PER    = 3;
  localparam int N_SRC    = 2 + N_EXT + N_PER;
  localparam int SRC_RST  = 0;
  localparam int SRC_SWI  = 1;
  localparam int SRC_EXT0 = 2;
  localparam int SRC_PER0 = SRC_EXT0 + N_EXT;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAKE = 2'd1,
    ST_STOP = 2'd2,
    ST_WAIT = 2'd3
  } pwrState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic             take;
    logic [N_SRC-1:0] grant;
  } ctlStb_t;
endpackage

// File: rtl/iwcDatapath.sv
module iwcDatapath
  import iwcPkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP     = 16'h3FFE,
  parameter int                SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_EXT-1:0]  extPinN,
  input  logic [N_EXT-1:0]  edgeSel,
  input  logic [N_PER-1:0]  perReq,
  input  logic              swiStb,
  input  ctlStb_t           ctl,
  output logic [N_SRC-1:0]  reqRaw,
  output logic              vecValid,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              pushReq,
  output logic              setMask,
  output logic [N_PER-1:0]  perAck
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [N_EXT-1:0] extReq;
  logic             swiPend;
  logic             rstPend;
  logic [ADDR_W-1:0] nextAddr;

  // per-pin synchronizer, falling-edge latch and mode select
  for (genvar i = 0; i < N_EXT; i++) begin : gExt
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevSync;
    logic                   pend;
    logic                   fall;

    assign fall = prevSync & ~chain[SYNC_MSB];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain    <= '1;
        prevSync <= 1'b1;
        pend     <= 1'b0;
      end else begin
        chain    <= {chain[SYNC_STAGES-2:0], extPinN[i]};
        prevSync <= chain[SYNC_MSB];
        if (!edgeSel[i])
          pend <= 1'b0;
        else if (fall)
          pend <= 1'b1;
        else if (ctl.grant[SRC_EXT0+i])
          pend <= 1'b0;
      end
    end

    assign extReq[i] = edgeSel[i] ? pend : ~chain[SYNC_MSB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swiPend <= 1'b0;
      rstPend <= 1'b1;
    end else begin
      if (swiStb)
        swiPend <= 1'b1;
      else if (ctl.grant[SRC_SWI])
        swiPend <= 1'b0;
      if (ctl.grant[SRC_RST])
        rstPend <= 1'b0;
    end
  end

  assign reqRaw = {perReq, extReq, swiPend, rstPend};

  // vector of source k lies 2*k bytes below the top pair
  always_comb begin
    nextAddr = VEC_TOP;
    for (int i = 0; i < N_SRC; i++)
      if (ctl.grant[i])
        nextAddr = VEC_TOP - ADDR_W'(2 * i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecAddr  <= VEC_TOP;
      pushReq  <= 1'b0;
      setMask  <= 1'b0;
      perAck   <= '0;
    end else begin
      vecValid <= ctl.take;
      pushReq  <= ctl.take & ~ctl.grant[SRC_RST];
      setMask  <= ctl.take;
      perAck   <= ctl.take ? ctl.grant[SRC_PER0 +: N_PER] : '0;
      if (ctl.take)
        vecAddr <= nextAddr;
    end
  end
endmodule

// File: rtl/iwcControl.sv
module iwcControl
  import iwcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SRC-1:0] reqRaw,
  input  logic             iMask,
  input  logic             stopStb,
  input  logic             waitStb,
  input  logic             rtcIntMode,
  output ctlStb_t          ctl,
  output logic             oscEn,
  output logic             cpuClkEn,
  output logic             perClkEn
);
  pwrState_t        state;
  pwrState_t        stateNxt;
  logic             busy;
  logic             stopDeep;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] grantOh;
  logic             canSel;
  logic             extWake;
  logic             anyWake;

  // hardware sources are masked, reset and software are not
  assign elig = reqRaw & ~{{(N_SRC-2){iMask}}, 2'b00};

  always_comb begin
    grantOh = '0;
    for (int i = 0; i < N_SRC; i++)
      if (elig[i] && grantOh == '0)
        grantOh[i] = 1'b1;
  end

  assign canSel = !busy &&
                  ((state == ST_RUN && !stopStb && !waitStb) || state == ST_WAKE);
  assign ctl.take  = canSel && (|elig);
  assign ctl.grant = ctl.take ? grantOh : '0;

  assign extWake = |reqRaw[SRC_EXT0 +: N_EXT];
  assign anyWake = |reqRaw[N_SRC-1:SRC_EXT0];

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:  if (stopStb) stateNxt = ST_STOP;
               else if (waitStb) stateNxt = ST_WAIT;
      ST_STOP: if (extWake) stateNxt = ST_WAKE;
      ST_WAIT: if (anyWake) stateNxt = ST_WAKE;
      ST_WAKE: stateNxt = ST_RUN;
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      busy     <= 1'b0;
      stopDeep <= 1'b0;
    end else begin
      state <= stateNxt;
      busy  <= ctl.take;
      if (state == ST_RUN && stopStb)
        stopDeep <= rtcIntMode;
    end
  end

  always_comb begin
    oscEn    = 1'b1;
    cpuClkEn = 1'b1;
    perClkEn = 1'b1;
    unique case (state)
      ST_STOP: begin
        cpuClkEn = 1'b0;
        oscEn    = !stopDeep;
        perClkEn = !stopDeep;
      end
      ST_WAIT: cpuClkEn = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/intWakeCtrl.sv
module intWakeCtrl
  import iwcPkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP     = 16'h3FFE,
  parameter int                SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_EXT-1:0]  extPinN,
  input  logic [N_EXT-1:0]  edgeSel,
  input  logic [N_PER-1:0]  perReq,
  input  logic              iMask,
  input  logic              swiStb,
  input  logic              stopStb,
  input  logic              waitStb,
  input  logic              rtcIntMode,
  output logic              vecValid,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              pushReq,
  output logic              setMask,
  output logic [N_PER-1:0]  perAck,
  output logic              oscEn,
  output logic              cpuClkEn,
  output logic              perClkEn
);
  ctlStb_t          ctl;
  logic [N_SRC-1:0] reqRaw;

  iwcDatapath #(
    .ADDR_W(ADDR_W), .VEC_TOP(VEC_TOP), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .edgeSel(edgeSel),
    .perReq(perReq), .swiStb(swiStb), .ctl(ctl), .reqRaw(reqRaw),
    .vecValid(vecValid), .vecAddr(vecAddr), .pushReq(pushReq),
    .setMask(setMask), .perAck(perAck)
  );

  iwcControl u_ctl (
    .clk(clk), .rstN(rstN), .reqRaw(reqRaw), .iMask(iMask),
    .stopStb(stopStb), .waitStb(waitStb), .rtcIntMode(rtcIntMode),
    .ctl(ctl), .oscEn(oscEn), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn)
  );
endmodule

// File: rtl/intWakeCtrlChecker.sv
module intWakeCtrlChecker #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP = 16'h3FFE
)(
  input logic              clk,
  input logic              rstN,
  input logic              iMask,
  input logic              vecValid,
  input logic [ADDR_W-1:0] vecAddr,
  input logic              pushReq,
  input logic              setMask,
  input logic [2:0]        perAck,
  input logic              oscEn,
  input logic              cpuClkEn,
  input logic              perClkEn
);
  localparam logic [ADDR_W-1:0] SWI_ADDR = VEC_TOP - ADDR_W'(2);

  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && !pushReq |-> vecAddr == VEC_TOP && setMask); // R1
  AST_SWI_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && vecAddr == SWI_ADDR |-> pushReq && setMask); // R2
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && pushReq && vecAddr < SWI_ADDR |-> !$past(iMask)); // R3
  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid); // R4
  AST_DEEP_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> !cpuClkEn && !perClkEn); // R7
  AST_LIGHT_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    oscEn && !cpuClkEn |-> perClkEn); // R9
  AST_NO_VEC_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    !cpuClkEn |-> !vecValid); // R10
  AST_WAKE_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClkEn) |-> !vecValid); // R10
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(perAck)); // R11
  AST_ACK_WITH_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (|perAck) |-> vecValid && pushReq); // R11
endmodule

bind intWakeCtrl intWakeCtrlChecker #(.ADDR_W(ADDR_W), .VEC_TOP(VEC_TOP)) u_chk (
  .clk(clk), .rstN(rstN), .iMask(iMask), .vecValid(vecValid),
  .vecAddr(vecAddr), .pushReq(pushReq), .setMask(setMask), .perAck(perAck),
  .oscEn(oscEn), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn)
);

// File: tb/intWakeCtrl_bench.sv
`timescale 1ns/1ps
module intWakeCtrl_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  extPinN, edgeSel, perReq;
  logic        iMask, swiStb, stopStb, waitStb, rtcIntMode;
  logic        vecValid, pushReq, setMask, oscEn, cpuClkEn, perClkEn;
  logic [15:0] vecAddr;
  logic [2:0]  perAck;
  int          nChecks = 0;
  int          nFail   = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  intWakeCtrl u_intWakeCtrl (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .edgeSel(edgeSel),
    .perReq(perReq), .iMask(iMask), .swiStb(swiStb), .stopStb(stopStb),
    .waitStb(waitStb), .rtcIntMode(rtcIntMode), .vecValid(vecValid),
    .vecAddr(vecAddr), .pushReq(pushReq), .setMask(setMask),
    .perAck(perAck), .oscEn(oscEn), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn)
  );

  function automatic logic [15:0] expAddr(int src);
    return 16'h3FFE - 16'(2 * src);
  endfunction

  function automatic int topSrc(logic [7:0] pend);
    for (int i = 0; i < 8; i++)
      if (pend[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chkVec(string req, logic [15:0] addr);
    chk(vecValid === 1'b1, req, "vecValid", 32'(vecValid), 32'd1);
    chk(vecAddr === addr, req, "vecAddr", 32'(vecAddr), 32'(addr));
  endtask

  task automatic chkNoVec(string req);
    chk(vecValid === 1'b0, req, "no vecValid", 32'(vecValid), 32'd0);
  endtask

  task automatic chkClk(string req, logic o, logic c, logic p);
    chk({oscEn, cpuClkEn, perClkEn} === {o, c, p}, req, "clock enables",
        32'({oscEn, cpuClkEn, perClkEn}), 32'({o, c, p}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; extPinN = '1; edgeSel = '0; perReq = '0; iMask = 1'b1;
    swiStb = 0; stopStb = 0; waitStb = 0; rtcIntMode = 0;
    repeat (3) tick();
    chkClk("R1", 1, 1, 1);
    chkNoVec("R1");
    rstN = 1'b1;
    tick();
    chkVec("R1", 16'h3FFE);
    chk(pushReq === 1'b0 && setMask === 1'b1, "R1", "push/mask", 32'({pushReq, setMask}), 32'b01);
    tick();
    chkNoVec("R4");

    // R6 level mode, masked pulse leaves nothing
    edgeSel = 3'b000; extPinN[0] = 1'b0;
    repeat (4) tick();
    extPinN[0] = 1'b1;
    repeat (4) tick();
    iMask = 1'b0;
    for (int k = 0; k < 4; k++) begin tick(); chkNoVec("R6"); end
    extPinN[0] = 1'b0;
    tick(); tick(); chkNoVec("R6");
    tick(); chkVec("R6", expAddr(2));
    chk(pushReq === 1'b1, "R6", "pushReq", 32'(pushReq), 32'd1);
    iMask = 1'b1; extPinN[0] = 1'b1;
    repeat (4) tick();

    // R5 edge mode on third pin
    edgeSel = 3'b100; iMask = 1'b0;
    extPinN[2] = 1'b0; tick(); tick();
    extPinN[2] = 1'b1; tick(); chkNoVec("R5");
    tick(); chkVec("R5", expAddr(4));
    iMask = 1'b1; repeat (3) tick();
    iMask = 1'b0;
    for (int k = 0; k < 5; k++) begin tick(); chkNoVec("R5"); end

    // R7 deep stop, peripheral cannot wake
    edgeSel = 3'b000; rtcIntMode = 1'b1;
    stopStb = 1'b1; tick(); stopStb = 1'b0;
    chkClk("R7", 0, 0, 0);
    perReq = 3'b001;
    for (int k = 0; k < 5; k++) begin tick(); chkClk("R7", 0, 0, 0); chkNoVec("R7"); end
    perReq = 3'b000; extPinN[1] = 1'b0;
    tick(); tick(); chkClk("R10", 0, 0, 0);
    tick(); chkClk("R10", 1, 1, 1); chkNoVec("R10");
    tick(); chkVec("R10", expAddr(3));
    iMask = 1'b1; extPinN[1] = 1'b1;
    repeat (4) tick();

    // R8 light stop, masked wake
    rtcIntMode = 1'b0; edgeSel = 3'b001;
    stopStb = 1'b1; tick(); stopStb = 1'b0;
    chkClk("R8", 1, 0, 1);
    extPinN[0] = 1'b0; tick(); tick();
    extPinN[0] = 1'b1; tick(); chkClk("R8", 1, 0, 1);
    tick(); chkClk("R10", 1, 1, 1); chkNoVec("R10");
    tick(); chkNoVec("R10");
    iMask = 1'b0;
    tick(); chkVec("R10", expAddr(2));
    iMask = 1'b1; repeat (3) tick();

    // R9 wait, woken by timer; R11 acknowledge
    iMask = 1'b0;
    waitStb = 1'b1; tick(); waitStb = 1'b0;
    chkClk("R9", 1, 0, 1);
    repeat (3) tick();
    chkClk("R9", 1, 0, 1);
    perReq = 3'b010;
    tick(); chkClk("R9", 1, 1, 1); chkNoVec("R9");
    tick(); chkVec("R9", expAddr(6));
    chk(perAck === 3'b010, "R11", "perAck", 32'(perAck), 32'b010);
    perReq = 3'b000; iMask = 1'b1; repeat (3) tick();

    // R12 wait strobe and serial request in the same cycle
    iMask = 1'b0;
    waitStb = 1'b1; perReq = 3'b100;
    tick(); waitStb = 1'b0;
    chkClk("R12", 1, 0, 1); chkNoVec("R12");
    tick(); chkClk("R12", 1, 1, 1); chkNoVec("R12");
    tick(); chkVec("R12", expAddr(7));
    chk(perAck === 3'b100, "R11", "perAck", 32'(perAck), 32'b100);
    perReq = 3'b000; iMask = 1'b1; repeat (3) tick();

    // random mixes: R2 R3 R4 R5 R11
    edgeSel = 3'b111;
    for (int t = 0; t < 40; t++) begin
      logic [2:0] extSel, perSel;
      logic [7:0] pend;
      bit         useSwi;
      int         seen;
      extSel = 3'($urandom); perSel = 3'($urandom); useSwi = 1'($urandom);
      if ({extSel, perSel} == 6'b0) perSel = 3'b001;
      iMask = 1'b1;
      extPinN = ~extSel; perReq = perSel;
      tick(); tick();
      extPinN = '1;
      for (int k = 0; k < 5; k++) begin tick(); chkNoVec("R3"); end
      if (useSwi) begin
        swiStb = 1'b1; tick(); swiStb = 1'b0; chkNoVec("R2");
        tick(); chkVec("R2", 16'h3FFC);
        chk(pushReq === 1'b1 && setMask === 1'b1, "R2", "push/mask",
            32'({pushReq, setMask}), 32'b11);
      end
      iMask = 1'b0;
      pend = {perSel, extSel, 2'b00};
      seen = 0;
      for (int k = 0; k < 40 && pend != 8'h00; k++) begin
        tick();
        if (vecValid === 1'b1) begin
          int s;
          s = topSrc(pend);
          chk(vecAddr === expAddr(s), "R4", "priority vector", 32'(vecAddr), 32'(expAddr(s)));
          if (s >= 5) begin
            chk(perAck === 3'(1 << (s - 5)), "R11", "perAck", 32'(perAck), 32'(1 << (s - 5)));
            perReq[s-5] = 1'b0;
          end
          pend[s] = 1'b0;
          seen++;
        end
      end
      chk(pend == 8'h00, "R3", "all pending served", 32'(pend), 32'd0);
      for (int k = 0; k < 4; k++) begin tick(); chkNoVec("R5"); end
    end

    // R1 reset during deep stop
    iMask = 1'b1; rtcIntMode = 1'b1;
    stopStb = 1'b1; tick(); stopStb = 1'b0;
    chkClk("R7", 0, 0, 0);
    rstN = 1'b0; #1;
    chkClk("R1", 1, 1, 1);
    tick(); rstN = 1'b1;
    tick(); chkVec("R1", 16'h3FFE);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule